// File: doc/BRIEF.md
# PLL Divide Ratio Selector and Dividers

This block produces the two integer divide ratios a frequency synthesiser loop needs: the feedback ratio applied to the oscillator clock and the reference ratio applied to the crystal clock. The synthesised frequency is the reference frequency multiplied by the feedback ratio and divided by the reference ratio. Two sources can set the ratios. In pin mode a single multiplier-select input picks one of two fixed multipliers, and the reference ratio is one. In programmed mode an 8-bit and a 6-bit configuration field are turned into ratios through offset formulas, and a bypass bit can force the reference ratio to one.

Both ratios also drive programmable down-counters in the same block. Each counter advances only on cycles where its enable is high, and it emits a one-cycle pulse each time it completes its ratio. A new ratio is picked up only when a counter reloads, so a count that is already running is never cut short or stretched. All logic runs on one clock with a synchronous, active-high reset.

The decoder has four named modes. MODE_PIN_X16 is pin mode with the select low. MODE_PIN_X8 is pin mode with the select high. MODE_PROG is programmed mode. MODE_PROG_QBYP is programmed mode with the reference bypass set. Each counter has two states. In CS_COUNT more than one enabled cycle remains, and each enabled cycle decrements the count; the counter moves to CS_LAST when the remaining count reaches one. In CS_LAST the next enabled cycle pulses and reloads, and the counter then stays in CS_LAST if the new ratio is one or returns to CS_COUNT otherwise. Reset loads either state from the current ratio.

Top module: `pll_ratio_sel`

## Requirements
- R1: With `prog_en` high, `p_ratio` equals (`p_field` + 3) × 2, so it is always even and lies between 6 and 516.
- R2: With `prog_en` high and `q_bypass` low, `q_ratio` equals `q_field` + 2, between 2 and 65.
- R3: With `prog_en` high and `q_bypass` high, `q_ratio` is 1 whatever `q_field` holds.
- R4: With `prog_en` low, `q_ratio` is 1. `p_ratio` is 16 when `mult_sel` is 0 and 8 when it is 1. A board that leaves the pin undriven presents a high level, which therefore selects 8.
- R5: `fb_pulse` is high for exactly the one cycle that follows every `p_ratio`-th cycle on which `vco_en` is high. Cycles with `vco_en` low do not advance the count, and `fb_pulse` is never high unless `vco_en` was high in the cycle before.
- R6: `ref_pulse` behaves the same way with `ref_en` and `q_ratio`. A ratio of 1 gives a pulse after every enabled cycle.
- R7: A ratio that changes while a count is in progress takes effect only when the counter next reloads, and the reload takes the ratio present on that cycle.
- R8: A cycle with `rst` high loads both counters from the ratios present on that cycle and drives both pulse outputs low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_en | input | 1 | 1 selects the programmed ratios, 0 selects pin mode |
| q_bypass | input | 1 | Forces the reference ratio to 1 in programmed mode |
| p_field | input | 8 | Programmed feedback field |
| q_field | input | 6 | Programmed reference field |
| mult_sel | input | 1 | Pin-mode multiplier select, 0 gives 16 and 1 gives 8 |
| ref_en | input | 1 | Reference clock enable, one per reference edge |
| vco_en | input | 1 | Oscillator clock enable, one per oscillator edge |
| p_ratio | output | 10 | Final feedback divide ratio |
| q_ratio | output | 7 | Final reference divide ratio |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback count |
| ref_pulse | output | 1 | One-cycle pulse at the end of each reference count |

## Verification
Two pairs of events can land on the same edge. A ratio change can meet the terminal count of a divider, and reset can meet an enabled cycle. The bench changes the fields and the mode at random on any cycle, including the reload cycle, and it also places a directed change exactly on a reload. Its reference model reloads with whatever ratio is present on the terminal edge, so one cycle's offset in when the new ratio is taken shows up as a misplaced pulse. It also holds the enables high through reset, and each reset must still produce a quiet cycle followed by a full count at the new ratio.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;
    localparam int P_FIELD_W = 8;
    localparam int Q_FIELD_W = 6;
    localparam int P_OFFSET  = 3;
    localparam int P_SCALE   = 2;
    localparam int Q_OFFSET  = 2;
    localparam int MULT_LOW  = 16;   // pin at 0
    localparam int MULT_HIGH = 8;    // pin at 1 (pull-up default)
    localparam int P_MAX     = ((1 << P_FIELD_W) - 1 + P_OFFSET) * P_SCALE;
    localparam int Q_MAX     = (1 << Q_FIELD_W) - 1 + Q_OFFSET;
    localparam int P_RATIO_W = $clog2(P_MAX + 1);
    localparam int Q_RATIO_W = $clog2(Q_MAX + 1);

    typedef enum logic [1:0] {
        MODE_PIN_X16,
        MODE_PIN_X8,
        MODE_PROG,
        MODE_PROG_QBYP
    } ratio_mode_e;

    typedef enum logic {
        CS_COUNT,
        CS_LAST
    } cnt_state_e;
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
    import pll_ratio_pkg::*;
(
    input  logic                 prog_en,
    input  logic                 q_bypass,
    input  logic [P_FIELD_W-1:0] p_field,
    input  logic [Q_FIELD_W-1:0] q_field,
    input  logic                 mult_sel,
    output logic [P_RATIO_W-1:0] p_ratio,
    output logic [Q_RATIO_W-1:0] q_ratio
);
    ratio_mode_e mode;
    logic [P_RATIO_W-1:0] p_sum;

    always_comb begin
        if (prog_en)
            mode = q_bypass ? MODE_PROG_QBYP : MODE_PROG;
        else
            mode = mult_sel ? MODE_PIN_X8 : MODE_PIN_X16;
    end

    assign p_sum = P_RATIO_W'(p_field) + P_RATIO_W'(P_OFFSET);

    always_comb begin
        unique case (mode)
            MODE_PIN_X16: begin
                p_ratio = P_RATIO_W'(MULT_LOW);
                q_ratio = Q_RATIO_W'(1);
            end
            MODE_PIN_X8: begin
                p_ratio = P_RATIO_W'(MULT_HIGH);
                q_ratio = Q_RATIO_W'(1);
            end
            MODE_PROG: begin
                p_ratio = P_RATIO_W'(p_sum * P_RATIO_W'(P_SCALE));
                q_ratio = Q_RATIO_W'(q_field) + Q_RATIO_W'(Q_OFFSET);
            end
            MODE_PROG_QBYP: begin
                p_ratio = P_RATIO_W'(p_sum * P_RATIO_W'(P_SCALE));
                q_ratio = Q_RATIO_W'(1);
            end
            default: begin
                p_ratio = P_RATIO_W'(MULT_LOW);
                q_ratio = Q_RATIO_W'(1);
            end
        endcase
    end

    always_comb begin
        if (prog_en) begin
            assert_p_even_R1: assert (p_ratio[0] == 1'b0 && p_ratio >= P_RATIO_W'(6));
        end
        if (prog_en && q_bypass) begin
            assert_qbyp_one_R3: assert (q_ratio == Q_RATIO_W'(1));
        end
        if (!prog_en) begin
            assert_pin_mode_R4: assert (q_ratio == Q_RATIO_W'(1) &&
                (p_ratio == P_RATIO_W'(MULT_LOW) || p_ratio == P_RATIO_W'(MULT_HIGH)));
        end
    end
endmodule

// File: rtl/ratio_counter.sv
module ratio_counter
    import pll_ratio_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    cnt_state_e   state;
    logic [W-1:0] remain;

    // state register: remaining count and its phase
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= ratio;
            state  <= (ratio == W'(1)) ? CS_LAST : CS_COUNT;
        end else if (en) begin
            unique case (state)
                CS_COUNT: begin
                    remain <= remain - W'(1);
                    state  <= (remain == W'(2)) ? CS_LAST : CS_COUNT;
                end
                CS_LAST: begin
                    remain <= ratio;
                    state  <= (ratio == W'(1)) ? CS_LAST : CS_COUNT;
                end
                default: begin
                    remain <= ratio;
                    state  <= CS_COUNT;
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= en && (state == CS_LAST);
    end

    // R5 / R6: a pulse only follows an enabled cycle
    assert_pulse_after_en_R5: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(en));

    // R7: terminal enabled cycle reloads from the ratio present then
    assert_reload_ratio_R7: assert property (@(posedge clk) disable iff (rst)
        (en && state == CS_LAST) |=> (remain == $past(ratio)));

    assert_remain_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        remain != W'(0));
endmodule

// File: rtl/pll_ratio_sel.sv
module pll_ratio_sel
    import pll_ratio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_en,
    input  logic                 q_bypass,
    input  logic [P_FIELD_W-1:0] p_field,
    input  logic [Q_FIELD_W-1:0] q_field,
    input  logic                 mult_sel,
    input  logic                 ref_en,
    input  logic                 vco_en,
    output logic [P_RATIO_W-1:0] p_ratio,
    output logic [Q_RATIO_W-1:0] q_ratio,
    output logic                 fb_pulse,
    output logic                 ref_pulse
);
    ratio_decode u_decode (
        .prog_en  (prog_en),
        .q_bypass (q_bypass),
        .p_field  (p_field),
        .q_field  (q_field),
        .mult_sel (mult_sel),
        .p_ratio  (p_ratio),
        .q_ratio  (q_ratio)
    );

    ratio_counter #(.W(P_RATIO_W)) u_fb_div (
        .clk   (clk),
        .rst   (rst),
        .en    (vco_en),
        .ratio (p_ratio),
        .pulse (fb_pulse)
    );

    ratio_counter #(.W(Q_RATIO_W)) u_ref_div (
        .clk   (clk),
        .rst   (rst),
        .en    (ref_en),
        .ratio (q_ratio),
        .pulse (ref_pulse)
    );

    // R8: the cycle after reset carries no pulse
    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> (!fb_pulse && !ref_pulse));
endmodule

// File: tb/pll_ratio_sel_tb.sv
module pll_ratio_sel_tb;
    logic       clk = 1'b0;
    logic       rst, prog_en, q_bypass, mult_sel, ref_en, vco_en;
    logic [7:0] p_field;
    logic [5:0] q_field;
    logic [9:0] p_ratio;
    logic [6:0] q_ratio;
    logic       fb_pulse, ref_pulse;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    int m_prem, m_qrem;
    bit m_fb, m_ref;

    always #5 clk = ~clk;

    pll_ratio_sel u_dut (
        .clk(clk), .rst(rst), .prog_en(prog_en), .q_bypass(q_bypass),
        .p_field(p_field), .q_field(q_field), .mult_sel(mult_sel),
        .ref_en(ref_en), .vco_en(vco_en), .p_ratio(p_ratio), .q_ratio(q_ratio),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
    );

    function automatic int exp_p();
        if (!prog_en) return mult_sel ? 8 : 16;
        return (int'(p_field) + 3) * 2;
    endfunction

    function automatic int exp_q();
        if (!prog_en || q_bypass) return 1;
        return int'(q_field) + 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // inputs already set at a falling edge; checks ratios, models the edge, checks pulses
    task automatic tick(string ptag, string qtag);
        int ep, eq;
        #1;
        ep = exp_p();
        eq = exp_q();
        if (!prog_en) check("R4 p_ratio", int'(p_ratio), ep);
        else          check("R1 p_ratio", int'(p_ratio), ep);
        if (!prog_en)      check("R4 q_ratio", int'(q_ratio), eq);
        else if (q_bypass) check("R3 q_ratio", int'(q_ratio), eq);
        else               check("R2 q_ratio", int'(q_ratio), eq);
        if (rst) begin
            m_prem = ep; m_qrem = eq; m_fb = 0; m_ref = 0;
        end else begin
            m_fb = 0; m_ref = 0;
            if (vco_en) begin
                if (m_prem == 1) begin m_fb = 1; m_prem = ep; end
                else m_prem--;
            end
            if (ref_en) begin
                if (m_qrem == 1) begin m_ref = 1; m_qrem = eq; end
                else m_qrem--;
            end
        end
        @(negedge clk);
        check(ptag, int'(fb_pulse), int'(m_fb));
        check(qtag, int'(ref_pulse), int'(m_ref));
    endtask

    task automatic plain_tick();
        tick("R5 fb_pulse", "R6 ref_pulse");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; prog_en = 0; q_bypass = 0; mult_sel = 1;
        ref_en = 1; vco_en = 1; p_field = 0; q_field = 0;
        @(negedge clk);
        tick("R8 fb_pulse", "R8 ref_pulse");
        tick("R8 fb_pulse", "R8 ref_pulse");
        rst = 0;

        // ratio 1 on reference: pulse after every enabled cycle (R6); x8 feedback (R4/R5)
        for (int i = 0; i < 20; i++) begin
            ref_en = (i != 7);
            tick("R5 fb_pulse", "R6 ref_pulse ratio1");
        end

        // pin low selects x16
        mult_sel = 0;
        for (int i = 0; i < 40; i++) plain_tick();

        // programmed minimum values, then a change mid-count (R7)
        prog_en = 1; p_field = 0; q_field = 0;
        rst = 1; tick("R8 fb_pulse", "R8 ref_pulse"); rst = 0;
        for (int i = 0; i < 3; i++) plain_tick();
        p_field = 5; q_field = 9;     // mid-count change
        for (int i = 0; i < 60; i++) tick("R7 fb_pulse", "R7 ref_pulse");

        // bypass forces q ratio 1 (R3)
        q_bypass = 1; q_field = 6'h3F;
        for (int i = 0; i < 10; i++) plain_tick();
        q_bypass = 0;

        // extreme fields
        p_field = 8'hFF; q_field = 6'h3F;
        for (int i = 0; i < 4; i++) plain_tick();
        p_field = 0; q_field = 0;
        for (int i = 0; i < 600; i++) tick("R7 fb_pulse", "R7 ref_pulse");

        // reset while enables held high (R8)
        rst = 1; tick("R8 fb_pulse", "R8 ref_pulse");
        rst = 0; tick("R8 fb_pulse", "R8 ref_pulse");

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            vco_en = ($urandom % 4) != 0;
            ref_en = ($urandom % 3) != 0;
            rst    = ($urandom % 400) == 0;
            if (($urandom % 16) == 0) begin
                prog_en  = ($urandom % 3) != 0;
                q_bypass = ($urandom % 4) == 0;
                mult_sel = $urandom % 2;
                p_field  = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 6);
                q_field  = 6'($urandom);
            end
            if (rst) tick("R8 fb_pulse", "R8 ref_pulse");
            else     plain_tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule